// File: doc/BRIEF.md
# Eight-Instruction Word-Addressed Processor Core

This block is a small multi-cycle 32-bit processor. It runs a load/store instruction set of eight operations: add, nand, load word, store word, branch-if-equal, jump-and-link-register, halt and no-op. The core steps through fetch, decode and execute for one instruction at a time. It has eight general registers, with register 0 fixed at zero, and a single unified memory that holds both instructions and data. The memory is addressed in whole 32-bit words, so consecutive words differ by one in address.

The memory sits inside the block. A loader port writes words into it, normally while the core is held in reset, and a peek port reads any word back combinationally. After reset is released, execution starts at address 0. When a halt is executed the core stops for good: `halted` rises and the program counter stays one past the halt. The architectural address is 16 bits wide. The physical depth is a parameter, and addresses wrap modulo that depth.

Top module: `tiny_word_cpu`

## Requirements
- R1: While reset is held and right after it, `pc` is 0 and `halted` is 0. Every general register reads 0 after reset, even if an earlier program set it.
- R2: Field layout: the opcode is in bits 24:22 (add=0, nand=1, lw=2, sw=3, beq=4, jalr=5, halt=6, noop=7), regA in bits 21:19, regB in bits 18:16 and the destination in bits 2:0. Add writes the 32-bit wrapping sum regA+regB into the destination.
- R3: Nand writes the bitwise inverse of (regA AND regB) into the destination.
- R4: Load word writes memory[regA + offset] into regB. The offset is bits 15:0, sign-extended, and addresses count in words.
- R5: Store word writes regB into memory[regA + offset], using the same address rule as R4.
- R6: Branch-if-equal sets the next PC to PC+1+offset when regA equals regB, and to PC+1 otherwise. Negative offsets branch backwards.
- R7: Jump-and-link-register writes PC+1 into regB and jumps to the value that regA held before the instruction. When regA and regB are the same register, the jump uses the old value.
- R8: Register 0 always reads as zero. Writes to it from add, nand or load are discarded.
- R9: After halt, `halted` stays 1 and `pc` holds the halt address plus one. No later instruction executes, and memory is not modified again.
- R10: No-op changes no register and no memory word. It only advances the PC by one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| ld_en | input | 1 | Loader write strobe into the internal memory |
| ld_addr | input | 16 | Loader word address |
| ld_data | input | 32 | Loader write data |
| pk_addr | input | 16 | Peek word address |
| pk_data | output | 32 | Combinational read of the memory word at `pk_addr` |
| halted | output | 1 | High once a halt has executed |
| pc | output | 16 | Current program counter |

## Verification
The registers are internal, so a wrong register value shows up only when a later store writes it to memory or a later branch or jump steers the program counter. Each directed program therefore ends its computation by storing results to fixed data words and then halting. The final `pc` value exposes a wrong branch target, link value or halt address within the 3 to 4 cycles one instruction takes. Marker words that a skipped path would overwrite, and words placed after a halt, show any instruction that runs when it should not.

// File: rtl/wcpu_pkg.sv
`timescale 1ns/1ps
package wcpu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_NAND = 3'd1,
    OP_LW   = 3'd2,
    OP_SW   = 3'd3,
    OP_BEQ  = 3'd4,
    OP_JALR = 3'd5,
    OP_HALT = 3'd6,
    OP_NOOP = 3'd7
  } opcode_e;

  typedef enum logic [2:0] {
    ST_FETCH  = 3'd0,
    ST_DECODE = 3'd1,
    ST_EXEC   = 3'd2,
    ST_LOAD   = 3'd3,
    ST_STOP   = 3'd4
  } phase_e;

  localparam int OPC_LSB  = 22;
  localparam int RA_LSB   = 19;
  localparam int RB_LSB   = 16;
  localparam int RD_LSB   = 0;
  localparam int IMM_BITS = 16;

endpackage

// File: rtl/wcpu_rst_sync.sv
`timescale 1ns/1ps
module wcpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/wcpu_regfile.sv
`timescale 1ns/1ps
module wcpu_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8,
  localparam int RIDX = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RIDX-1:0] rsel_a,
  input  logic [RIDX-1:0] rsel_b,
  output logic [XLEN-1:0] rval_a,
  output logic [XLEN-1:0] rval_b,
  input  logic            wr_en,
  input  logic [RIDX-1:0] wr_sel,
  input  logic [XLEN-1:0] wr_val
);
  logic [XLEN-1:0] bank [NREG];

  assign bank[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic            hit;
    logic [XLEN-1:0] q;
    assign hit = wr_en && (wr_sel == RIDX'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_val;
    end
    assign bank[g] = q;
  end

  assign rval_a = bank[rsel_a];
  assign rval_b = bank[rsel_b];

  // R8: a write aimed at register 0 leaves it reading zero on the next cycle
  a_r8_zero_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == '0 && rsel_a == '0) |=> (rsel_a != '0 || rval_a == '0));
endmodule

// File: rtl/wcpu_alu.sv
`timescale 1ns/1ps
module wcpu_alu #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  input  logic            do_nand,
  output logic [XLEN-1:0] result,
  output logic            same
);
  always_comb begin
    if (do_nand) result = ~(opnd_a & opnd_b);
    else         result = opnd_a + opnd_b;
  end
  assign same = (opnd_a == opnd_b);
endmodule

// File: rtl/wcpu_mem.sv
`timescale 1ns/1ps
module wcpu_mem #(
  parameter int XLEN   = 32,
  parameter int MEM_AW = 10,
  localparam int DEPTH = 1 << MEM_AW
) (
  input  logic              clk,
  input  logic [MEM_AW-1:0] rd_idx,
  output logic [XLEN-1:0]   rd_word,
  input  logic              wr_en,
  input  logic [MEM_AW-1:0] wr_idx,
  input  logic [XLEN-1:0]   wr_word,
  input  logic [MEM_AW-1:0] pk_idx,
  output logic [XLEN-1:0]   pk_word
);
  logic [XLEN-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[wr_idx] <= wr_word;
    rd_word <= cells[rd_idx];
  end

  assign pk_word = cells[pk_idx];
endmodule

// File: rtl/tiny_word_cpu.sv
`timescale 1ns/1ps
module tiny_word_cpu #(
  parameter int XLEN   = 32,
  parameter int AW     = 16,
  parameter int NREG   = 8,
  parameter int MEM_AW = 10
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ld_en,
  input  logic [AW-1:0]   ld_addr,
  input  logic [XLEN-1:0] ld_data,
  input  logic [AW-1:0]   pk_addr,
  output logic [XLEN-1:0] pk_data,
  output logic            halted,
  output logic [AW-1:0]   pc
);
  import wcpu_pkg::*;

  localparam int RIDX = $clog2(NREG);

  logic rst_ni;

  phase_e          state_q, state_d;
  logic [AW-1:0]   pc_q, pc_d;
  logic            pc_en;
  logic [XLEN-1:0] ir_q;
  logic            ir_en;

  opcode_e         op;
  logic [RIDX-1:0] ra_sel, rb_sel, rd_sel;
  logic [XLEN-1:0] imm_sx;
  logic [XLEN-1:0] ra_val, rb_val;
  logic [XLEN-1:0] alu_y;
  logic            alu_eq;
  logic [AW-1:0]   pc_inc, br_tgt;
  logic [XLEN-1:0] ea_full;
  logic [AW-1:0]   ea;

  logic            rf_we;
  logic [RIDX-1:0] rf_wsel;
  logic [XLEN-1:0] rf_wval;

  logic [AW-1:0]   fetch_addr;
  logic            core_we;
  logic [XLEN-1:0] mem_rd;
  logic            m_we;
  logic [AW-1:0]   m_waddr;
  logic [XLEN-1:0] m_wdata;

  wcpu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_ni)
  );

  // instruction fields
  assign op     = opcode_e'(ir_q[OPC_LSB +: 3]);
  assign ra_sel = ir_q[RA_LSB +: RIDX];
  assign rb_sel = ir_q[RB_LSB +: RIDX];
  assign rd_sel = ir_q[RD_LSB +: RIDX];
  assign imm_sx = {{(XLEN-IMM_BITS){ir_q[IMM_BITS-1]}}, ir_q[IMM_BITS-1:0]};

  wcpu_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk    (clk),
    .rst_n  (rst_ni),
    .rsel_a (ra_sel),
    .rsel_b (rb_sel),
    .rval_a (ra_val),
    .rval_b (rb_val),
    .wr_en  (rf_we),
    .wr_sel (rf_wsel),
    .wr_val (rf_wval)
  );

  wcpu_alu #(.XLEN(XLEN)) u_alu (
    .opnd_a  (ra_val),
    .opnd_b  (rb_val),
    .do_nand (op == OP_NAND),
    .result  (alu_y),
    .same    (alu_eq)
  );

  assign pc_inc  = pc_q + AW'(1);
  assign br_tgt  = pc_inc + imm_sx[AW-1:0];
  assign ea_full = ra_val + imm_sx;
  assign ea      = ea_full[AW-1:0];

  // next-state and datapath control
  always_comb begin
    state_d    = state_q;
    pc_d       = pc_q;
    pc_en      = 1'b0;
    ir_en      = 1'b0;
    rf_we      = 1'b0;
    rf_wsel    = rd_sel;
    rf_wval    = alu_y;
    fetch_addr = pc_q;
    core_we    = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        fetch_addr = pc_q;
        state_d    = ST_DECODE;
      end
      ST_DECODE: begin
        ir_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        pc_en   = 1'b1;
        pc_d    = pc_inc;
        state_d = ST_FETCH;
        unique case (op)
          OP_ADD, OP_NAND: begin
            rf_we = 1'b1;
          end
          OP_LW: begin
            pc_en      = 1'b0;
            fetch_addr = ea;
            state_d    = ST_LOAD;
          end
          OP_SW: begin
            core_we = 1'b1;
          end
          OP_BEQ: begin
            if (alu_eq) pc_d = br_tgt;
          end
          OP_JALR: begin
            rf_we   = 1'b1;
            rf_wsel = rb_sel;
            rf_wval = {{(XLEN-AW){1'b0}}, pc_inc};
            pc_d    = ra_val[AW-1:0];
          end
          OP_HALT: begin
            state_d = ST_STOP;
          end
          default: begin
          end
        endcase
      end
      ST_LOAD: begin
        rf_we   = 1'b1;
        rf_wsel = rb_sel;
        rf_wval = mem_rd;
        pc_en   = 1'b1;
        pc_d    = pc_inc;
        state_d = ST_FETCH;
      end
      default: begin
        state_d = ST_STOP;
      end
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_FETCH;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    ir_q <= '0;
    else if (ir_en) ir_q <= mem_rd;
  end

  // memory, loader has priority on the write port
  assign m_we    = ld_en | core_we;
  assign m_waddr = ld_en ? ld_addr : ea;
  assign m_wdata = ld_en ? ld_data : rb_val;

  wcpu_mem #(.XLEN(XLEN), .MEM_AW(MEM_AW)) u_mem (
    .clk     (clk),
    .rd_idx  (fetch_addr[MEM_AW-1:0]),
    .rd_word (mem_rd),
    .wr_en   (m_we),
    .wr_idx  (m_waddr[MEM_AW-1:0]),
    .wr_word (m_wdata),
    .pk_idx  (pk_addr[MEM_AW-1:0]),
    .pk_word (pk_data)
  );

  assign halted = (state_q == ST_STOP);
  assign pc     = pc_q;

  logic unused_bits;
  assign unused_bits = ^{ir_q, ea_full, fetch_addr, m_waddr, pk_addr};

  // R9: halt is permanent, the PC freezes and no store happens afterwards
  a_r9_halt_sticky: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> halted);
  a_r9_pc_frozen: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |=> $stable(pc_q));
  a_r9_no_store_halted: assert property (@(posedge clk) disable iff (!rst_ni)
    halted |-> !core_we);
  // R6: a taken branch lands on PC+1+offset
  a_r6_beq_target: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_BEQ && alu_eq) |=> (pc_q == $past(br_tgt)));
  // R7: jalr jumps to the value regA held before the instruction
  a_r7_jalr_old_value: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_JALR) |=> (pc_q == $past(ra_val[AW-1:0])));
  // R10: noop advances the PC by exactly one
  a_r10_noop_step: assert property (@(posedge clk) disable iff (!rst_ni)
    (state_q == ST_EXEC && op == OP_NOOP) |=> (pc_q == $past(pc_q) + AW'(1)));
endmodule

// File: tb/sim_tiny_word_cpu.sv
`timescale 1ns/1ps
module sim_tiny_word_cpu;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_en;
  logic [15:0] ld_addr;
  logic [31:0] ld_data;
  logic [15:0] pk_addr;
  logic [31:0] pk_data;
  logic        halted;
  logic [15:0] pc;

  int n_cmp = 0;
  int n_bad = 0;

  localparam int ADD = 0, NAND = 1, LW = 2, SW = 3, BEQ = 4, JALR = 5, HALT = 6, NOOP = 7;

  always #10 clk = ~clk;

  tiny_word_cpu u0 (
    .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pk_addr(pk_addr), .pk_data(pk_data), .halted(halted), .pc(pc)
  );

  function automatic logic [31:0] ins_i(int op, int a, int b, int off);
    return {7'b0, op[2:0], a[2:0], b[2:0], off[15:0]};
  endfunction

  function automatic logic [31:0] ins_r(int op, int a, int b, int d);
    return {7'b0, op[2:0], a[2:0], b[2:0], 13'b0, d[2:0]};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic peek_chk(string tag, int addr, logic [31:0] exp);
    pk_addr = addr[15:0];
    #1;
    chk(tag, pk_data, exp);
  endtask

  task automatic begin_prog();
    @(negedge clk);
    rst_n = 1'b0;
    ld_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic put(int addr, logic [31:0] w);
    ld_en   = 1'b1;
    ld_addr = addr[15:0];
    ld_data = w;
    @(negedge clk);
    ld_en   = 1'b0;
  endtask

  task automatic run(string tag);
    int cyc = 0;
    rst_n = 1'b1;
    while (!halted && cyc < 2000) begin
      @(negedge clk);
      cyc++;
    end
    if (!halted) begin
      n_cmp++;
      n_bad++;
      $display("FAIL %s actual=running expected=halted", tag);
    end
  endtask

  task automatic t_reset_outputs();
    begin_prog();
    chk("R1 pc in reset", {16'b0, pc}, 32'd0);
    chk("R1 halted in reset", {31'b0, halted}, 32'd0);
    put(100, 32'hDEAD_BEEF);
    put(0, ins_i(SW, 0, 1, 100));
    put(1, ins_i(HALT, 0, 0, 0));
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc after release", {16'b0, pc}, 32'd0);
    run("R1 reset program");
    peek_chk("R1 r1 zero after reset", 100, 32'd0);
    chk("R9 pc after halt", {16'b0, pc}, 32'd2);
  endtask

  task automatic t_alu();
    begin_prog();
    put(100, 32'hFFFF_FFF0);
    put(101, 32'h0000_0025);
    put(0, ins_i(LW, 0, 1, 100));
    put(1, ins_i(LW, 0, 2, 101));
    put(2, ins_r(ADD, 1, 2, 3));
    put(3, ins_r(NAND, 1, 2, 4));
    put(4, ins_i(SW, 0, 3, 102));
    put(5, ins_i(SW, 0, 4, 103));
    put(6, ins_i(HALT, 0, 0, 0));
    run("R2 alu program");
    peek_chk("R2 add wraps", 102, 32'h0000_0015);
    peek_chk("R3 nand", 103, 32'hFFFF_FFDF);
    peek_chk("R4 load kept source", 101, 32'h0000_0025);
  endtask

  task automatic t_reset_regs();
    begin_prog();
    put(100, 32'h1111_1111);
    put(101, 32'h2222_2222);
    put(0, ins_i(SW, 0, 1, 100));
    put(1, ins_i(SW, 0, 4, 101));
    put(2, ins_i(HALT, 0, 0, 0));
    run("R1 regs program");
    peek_chk("R1 r1 cleared", 100, 32'd0);
    peek_chk("R1 r4 cleared", 101, 32'd0);
  endtask

  task automatic t_mem_offsets();
    begin_prog();
    put(100, 32'd105);
    put(102, 32'hCAFE_F00D);
    put(110, 32'd0);
    put(0, ins_i(LW, 0, 1, 100));
    put(1, ins_i(LW, 1, 2, -3));
    put(2, ins_i(SW, 1, 2, 5));
    put(3, ins_i(HALT, 0, 0, 0));
    run("R4 offset program");
    peek_chk("R4 R5 negative then positive offset", 110, 32'hCAFE_F00D);
    chk("R9 pc after halt", {16'b0, pc}, 32'd4);
  endtask

  task automatic t_branch();
    begin_prog();
    put(100, 32'd7);
    put(101, 32'd7);
    put(110, 32'd0);
    put(111, 32'd0);
    put(112, 32'd0);
    put(0, ins_i(LW, 0, 1, 100));
    put(1, ins_i(LW, 0, 2, 101));
    put(2, ins_i(BEQ, 1, 2, 3));
    put(3, ins_i(SW, 0, 1, 110));
    put(4, ins_i(HALT, 0, 0, 0));
    put(5, ins_i(SW, 0, 2, 112));
    put(6, ins_i(BEQ, 1, 0, 5));
    put(7, ins_i(SW, 0, 1, 111));
    put(8, ins_i(BEQ, 0, 0, -6));
    run("R6 branch program");
    peek_chk("R6 backward taken", 110, 32'd7);
    peek_chk("R6 not taken falls through", 111, 32'd7);
    peek_chk("R6 forward taken skips", 112, 32'd0);
    chk("R6 final pc", {16'b0, pc}, 32'd5);
  endtask

  task automatic t_jalr();
    begin_prog();
    put(100, 32'd5);
    put(101, 32'd2);
    put(110, 32'd0);
    put(111, 32'd0);
    put(0, ins_i(LW, 0, 1, 100));
    put(1, ins_i(JALR, 1, 2, 0));
    put(2, ins_i(SW, 0, 3, 111));
    put(3, ins_i(HALT, 0, 0, 0));
    put(5, ins_i(LW, 0, 3, 101));
    put(6, ins_i(SW, 0, 2, 110));
    put(7, ins_i(JALR, 3, 3, 0));
    run("R7 jalr program");
    peek_chk("R7 link value", 110, 32'd2);
    peek_chk("R7 same reg link", 111, 32'd8);
    chk("R7 returned to old target", {16'b0, pc}, 32'd4);
  endtask

  task automatic t_r0_noop();
    begin_prog();
    put(100, 32'h0000_1234);
    put(110, 32'h0000_FFFF);
    put(111, 32'd0);
    put(0, ins_i(LW, 0, 1, 100));
    put(1, ins_i(LW, 0, 0, 100));
    put(2, ins_r(ADD, 1, 1, 0));
    put(3, ins_i(SW, 0, 0, 110));
    put(4, ins_i(NOOP, 1, 1, 0));
    put(5, ins_i(SW, 0, 1, 111));
    put(6, ins_i(HALT, 0, 0, 0));
    run("R8 r0 program");
    peek_chk("R8 r0 stays zero", 110, 32'd0);
    peek_chk("R10 noop kept r1", 111, 32'h0000_1234);
    peek_chk("R10 noop left memory", 100, 32'h0000_1234);
    chk("R10 pc counted noop", {16'b0, pc}, 32'd7);
  endtask

  task automatic t_halt_stops();
    logic [15:0] pc_at_halt;
    begin_prog();
    put(110, 32'h0000_0055);
    put(0, ins_i(HALT, 0, 0, 0));
    put(1, ins_i(SW, 0, 0, 110));
    put(2, ins_i(BEQ, 0, 0, -3));
    run("R9 halt program");
    pc_at_halt = pc;
    repeat (20) @(negedge clk);
    chk("R9 halted held", {31'b0, halted}, 32'd1);
    chk("R9 pc held", {16'b0, pc}, {16'b0, pc_at_halt});
    chk("R9 pc value", {16'b0, pc}, 32'd1);
    peek_chk("R9 no store after halt", 110, 32'h0000_0055);
  endtask

  initial begin
    rst_n   = 1'b0;
    ld_en   = 1'b0;
    ld_addr = '0;
    ld_data = '0;
    pk_addr = '0;
    t_reset_outputs();
    t_alu();
    t_reset_regs();
    t_mem_offsets();
    t_branch();
    t_jalr();
    t_r0_noop();
    t_halt_stops();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule